// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a host physical address into a DRAM row choice. Software programs one cumulative boundary per row through a small byte-wide register port. Each row covers the span that starts at the previous row's boundary and stops at its own boundary. Boundaries are counted in fixed units of a configurable number of megabytes. Row 0 always starts at address zero.

Each boundary has ten significant bits. The low eight bits sit in a per-row byte register. The top two bits sit in a shared extension register, and each extension register holds the upper bits of two neighbouring rows. The decoder is purely combinational from the host address. It gives a one-hot row select, a hit flag and the offset of the address inside the selected row, so a memory controller can use the result in the same cycle. Register writes take effect on the next clock edge.

If a row's boundary is below its predecessor's, the row is empty. Later rows still start from that lower boundary, so two rows can overlap. When they do, the lower-numbered row takes the address.

Top module: `rowdec_top`

## Requirements
- R1: After reset, every row's low-byte register (index r = 0..7) reads back the default 8'h10. Every extension register (index 8..11) reads back 8'h00.
- R2: Row 0 begins at address 0. Row r > 0 begins at boundary(r-1) × unit. Row r hits for base ≤ address < boundary(r) × unit, with unit = 1 MB.
- R3: boundary(r) = low byte of row r + 256 × field, where the field is taken from extension register 8 + (r >> 1). Even rows use bits [1:0] of that register and odd rows use bits [5:4]. Bits [3:2] and [7:6] are not stored and read back as zero.
- R4: A row whose boundary is lower than its predecessor's never hits. A row whose boundary equals its predecessor's also never hits.
- R5: A write to one low-byte register changes only that row's boundary. A write to an extension register changes only the two rows that share it, and leaves every other register's read-back unchanged.
- R6: On a hit, row_offset equals host_addr minus the selected row's base. On a miss, row_offset is 0.
- R7: row_sel is one-hot on a hit and all zero on a miss, and row_hit equals "any row_sel bit set". When the spans of several rows contain the address, the lowest-numbered row is selected.
- R8: Straight after reset, row 0 covers 0 to 16 MB. Any address at or above 16 MB misses, because every later row is empty.
- R9: Writes to register indices 12 and above are ignored, and reads from those indices return 0.
- R10: A register write changes the read-back and the decode from the clock edge that captures it onward. A change of host_addr changes the decode outputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 8 | Register index for read and write |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 8 | Combinational read-back of register reg_idx |
| host_addr | input | 32 | Host physical address to decode |
| row_sel | output | 8 | One-hot selected row |
| row_hit | output | 1 | Some row claims the address |
| row_offset | output | 32 | Address relative to the selected row's base |

## Verification
The decoder is tried with four kinds of boundary setup:
- The reset setup, where only row 0 is live.
- A strictly rising staircase of rows, probed one below, at, and one below the top of every edge. This separates an off-by-one at a base from one at a limit.
- Setups that use the extension fields, which show whether the even and odd nibbles are taken from the correct bits.
- A descending boundary that empties a row and lets a later row overlap an earlier one. This separates lowest-wins priority from highest-wins priority and from ignoring the empty flag.

A long run of random register writes and random addresses, some of them to unused indices, is then compared every cycle against a behavioural model. It catches crosstalk between neighbouring rows.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

  typedef logic [63:0] wide_t;

  localparam int BND_MAX_W = 16;
  localparam int EXT_W     = 2;
  localparam int MB_SHIFT  = 20;

  typedef logic [BND_MAX_W-1:0] bnd_t;

  // Take the significant extension bits of one row out of a shared register byte.
  function automatic logic [EXT_W-1:0] ext_slice(input logic [7:0] d, input logic odd);
    return odd ? d[5:4] : d[1:0];
  endfunction

  // Rebuild a shared extension byte from the fields of its two rows.
  function automatic logic [7:0] ext_pack(input logic [EXT_W-1:0] even_f,
                                          input logic [EXT_W-1:0] odd_f);
    return {2'b00, odd_f, 2'b00, even_f};
  endfunction

  // Full boundary: low byte with extension above it, masked to sig bits.
  function automatic bnd_t join_bound(input logic [7:0] low, input logic [EXT_W-1:0] ext,
                                      input int sig);
    bnd_t raw;
    bnd_t res;
    raw = bnd_t'({ext, low});
    for (int i = 0; i < BND_MAX_W; i++)
      res[i] = (i < sig) ? raw[i] : 1'b0;
    return res;
  endfunction

  // Boundary in units converted to a byte address.
  function automatic wide_t scale(input bnd_t bnd, input int unit_mb);
    wide_t unit_bytes;
    unit_bytes = wide_t'(unit_mb) << MB_SHIFT;
    return wide_t'(bnd) * unit_bytes;
  endfunction

endpackage

// File: rtl/rowdec_regs.sv
module rowdec_regs
  import rowdec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int IDX_W    = 8,
  parameter int LOW_W    = 8,
  parameter logic [LOW_W-1:0] DEF_LOW = 8'h10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [LOW_W-1:0] wdata,
  input  logic we,
  output logic [LOW_W-1:0] rdata,
  output logic [NUM_ROWS-1:0][LOW_W-1:0] low_q,
  output logic [NUM_ROWS-1:0][EXT_W-1:0] ext_q
);
  // Register file: one low byte per row, then shared extension bytes.
  // NUM_ROWS is expected to be even.
  localparam int EXT_BASE  = NUM_ROWS;
  localparam int NUM_EXT   = (NUM_ROWS + 1) / 2;
  localparam int REG_COUNT = EXT_BASE + NUM_EXT;

  logic [NUM_ROWS-1:0] low_wr;
  logic [NUM_ROWS-1:0] ext_wr;
  logic idx_unmapped;

  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      low_wr[r] = we && (int'(idx) == r);
      ext_wr[r] = we && (int'(idx) == EXT_BASE + r / 2);
    end
    idx_unmapped = int'(idx) >= REG_COUNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        low_q[r] <= DEF_LOW;
        ext_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (low_wr[r]) low_q[r] <= wdata;
        if (ext_wr[r]) ext_q[r] <= ext_slice(wdata, (r % 2) == 1);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_ROWS; r++)
      if (int'(idx) == r) rdata = low_q[r];
    for (int k = 0; k < NUM_EXT; k++)
      if (int'(idx) == EXT_BASE + k) rdata = ext_pack(ext_q[2*k], ext_q[2*k+1]);
  end

  // R1: reset loads the defaults
  a_r1_reset_defaults: assert property (@(posedge clk)
    !rst_n |=> (low_q[0] == DEF_LOW) && (ext_q == '0));

  // R9: unmapped writes touch nothing
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx_unmapped) |=> ($stable(low_q) && $stable(ext_q)));

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_chk
    // R5: a row's registers move only when that row is addressed
    a_r5_low_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !low_wr[g] |=> $stable(low_q[g]));
    a_r5_ext_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_wr[g] |=> $stable(ext_q[g]));
  end

endmodule

// File: rtl/rowdec_window.sv
module rowdec_window
  import rowdec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int UNIT_MB = 1
) (
  input  bnd_t prev_bnd,
  input  bnd_t cur_bnd,
  input  logic [ADDR_W-1:0] addr,
  output wide_t base,
  output wide_t limit,
  output logic empty,
  output logic cand
);
  // Span of one row: [prev boundary, own boundary) in bytes.
  wide_t addr_w;

  always_comb begin
    addr_w = wide_t'(addr);
    base   = scale(prev_bnd, UNIT_MB);
    limit  = scale(cur_bnd, UNIT_MB);
    empty  = prev_bnd >= cur_bnd;
    cand   = !empty && (addr_w >= base) && (addr_w < limit);
  end

endmodule

// File: rtl/rowdec_pick.sv
module rowdec_pick
  import rowdec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ADDR_W   = 32
) (
  input  logic [NUM_ROWS-1:0] cand,
  input  logic [NUM_ROWS-1:0][63:0] bases,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_ROWS-1:0] sel,
  output logic hit,
  output logic [ADDR_W-1:0] offset
);
  // Priority pick: scanning downward lets the lowest candidate win.
  always_comb begin
    sel    = '0;
    offset = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (cand[r]) begin
        sel    = '0;
        sel[r] = 1'b1;
        offset = addr - bases[r][ADDR_W-1:0];
      end
    end
    hit = |cand;
  end

endmodule

// File: rtl/rowdec_top.sv
module rowdec_top
  import rowdec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int LOW_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 8,
  parameter int UNIT_MB  = 1,
  parameter int SIG_BITS = 10,
  parameter logic [LOW_W-1:0] DEF_LOW = 8'h10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [LOW_W-1:0] reg_wdata,
  input  logic reg_we,
  output logic [LOW_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic row_hit,
  output logic [ADDR_W-1:0] row_offset
);
  logic [NUM_ROWS-1:0][LOW_W-1:0] low_q;
  logic [NUM_ROWS-1:0][EXT_W-1:0] ext_q;
  logic [NUM_ROWS-1:0][BND_MAX_W-1:0] bnd;
  logic [NUM_ROWS-1:0][63:0] win_base;
  logic [NUM_ROWS-1:0][63:0] win_limit;
  logic [NUM_ROWS-1:0] win_empty;
  logic [NUM_ROWS-1:0] win_cand;

  rowdec_regs #(
    .NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W), .LOW_W(LOW_W), .DEF_LOW(DEF_LOW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(reg_idx), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .low_q(low_q), .ext_q(ext_q)
  );

  always_comb
    for (int r = 0; r < NUM_ROWS; r++)
      bnd[r] = join_bound(low_q[r], ext_q[r], SIG_BITS);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    bnd_t prev;
    if (g == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = bnd[g-1];
    end

    rowdec_window #(.ADDR_W(ADDR_W), .UNIT_MB(UNIT_MB)) u_win (
      .prev_bnd(prev), .cur_bnd(bnd[g]), .addr(host_addr),
      .base(win_base[g]), .limit(win_limit[g]),
      .empty(win_empty[g]), .cand(win_cand[g])
    );

    // R4: an empty row is never selected
    a_r4_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
      win_empty[g] |-> !row_sel[g]);
    // R6: the offset stays inside the selected row
    a_r6_offset_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      row_sel[g] |-> (wide_t'(row_offset) < (win_limit[g] - win_base[g])));
    if (g > 0) begin : g_prio
      // R7: no lower-numbered candidate is passed over
      a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel[g] |-> (win_cand[g-1:0] == '0));
    end
  end

  rowdec_pick #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_pick (
    .cand(win_cand), .bases(win_base), .addr(host_addr),
    .sel(row_sel), .hit(row_hit), .offset(row_offset)
  );

  // R7: selection is one-hot and agrees with the hit flag
  a_r7_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel) && (row_hit == (row_sel != '0)));
  // R6: a miss reports a zero offset
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !row_hit |-> (row_offset == '0));

endmodule

// File: tb/tb_rowdec_top.sv
`timescale 1ns/1ps
module tb_rowdec_top;
  localparam longint MB = 64'd1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [31:0] host_addr = '0;
  logic [7:0] row_sel;
  logic row_hit;
  logic [31:0] row_offset;

  always #5 clk = ~clk;

  rowdec_top dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .host_addr(host_addr),
    .row_sel(row_sel), .row_hit(row_hit), .row_offset(row_offset)
  );

  // Behavioural reference model
  int lowm[8];
  int extm[8];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 8; r++) begin lowm[r] = 16; extm[r] = 0; end
    end else if (reg_we) begin
      if (reg_idx < 8) lowm[reg_idx] = reg_wdata;
      else if (reg_idx < 12) begin
        extm[(reg_idx - 8) * 2]     = reg_wdata & 3;
        extm[(reg_idx - 8) * 2 + 1] = (reg_wdata >> 4) & 3;
      end
    end
  end

  function automatic longint bound_of(int r);
    return longint'((lowm[r] + extm[r] * 256) & 1023);
  endfunction

  function automatic int exp_read(int idx);
    if (idx < 8) return lowm[idx];
    if (idx < 12) return extm[(idx - 8) * 2] + extm[(idx - 8) * 2 + 1] * 16;
    return 0;
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    longint a;
    longint lo;
    longint hi;
    longint esel = 0;
    longint eoff = 0;
    bit found = 0;
    a = longint'(host_addr);
    for (int r = 0; r < 8; r++) begin
      lo = (r == 0) ? 0 : bound_of(r - 1) * MB;
      hi = bound_of(r) * MB;
      if (!found && (r == 0 || bound_of(r - 1) < bound_of(r)) && a >= lo && a < hi) begin
        found = 1;
        esel = longint'(1) << r;
        eoff = a - lo;
      end
    end
    check("row_sel", longint'(row_sel), esel);
    check("row_hit", longint'(row_hit), longint'(found));
    check("row_offset", longint'(row_offset), eoff);
    check("reg_rdata", longint'(reg_rdata), longint'(exp_read(int'(reg_idx))));
  endtask

  task automatic step(logic [7:0] idx, logic [7:0] wd, logic we, logic [31:0] addr);
    @(negedge clk);
    reg_idx = idx; reg_wdata = wd; reg_we = we; host_addr = addr;
    #1;
    if (rst_n) compare();
  endtask

  task automatic wr(int idx, int data);
    step(8'(idx), 8'(data), 1'b1, host_addr);
    step(8'(idx), 8'h00, 1'b0, host_addr);
  endtask

  task automatic probe(longint addr);
    step(reg_idx, 8'h00, 1'b0, 32'(addr));
  endtask

  task automatic probe_edges(int r);
    longint lo;
    longint hi;
    lo = (r == 0) ? 0 : bound_of(r - 1) * MB;
    hi = bound_of(r) * MB;
    if (lo > 0) probe(lo - 1);
    probe(lo);
    probe(lo + 12345);
    if (hi > 0) probe(hi - 1);
    probe(hi);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 12; i++) step(8'(i), 8'h00, 1'b0, 32'h0);

    cur_req = "R8";
    probe(16 * MB - 1); probe(16 * MB); probe(64'hFFFF_FFFF); probe(0);

    cur_req = "R10";
    step(8'd0, 8'h18, 1'b1, 32'(20 * MB));
    step(8'd0, 8'h00, 1'b0, 32'(20 * MB));
    probe(23 * MB); probe(24 * MB);

    cur_req = "R2";
    for (int r = 0; r < 8; r++) wr(r, 16 * (r + 1));
    for (int r = 0; r < 8; r++) probe_edges(r);

    cur_req = "R3";
    wr(8, 8'hFF);
    step(8'd8, 8'h00, 1'b0, 32'h0);
    wr(8, 8'h21);
    wr(9, 8'h12);
    wr(10, 8'h33);
    for (int r = 0; r < 6; r++) probe_edges(r);

    cur_req = "R5";
    for (int i = 0; i < 12; i++) step(8'(i), 8'h00, 1'b0, 32'(300 * MB));
    wr(2, 8'h40);
    for (int i = 0; i < 12; i++) step(8'(i), 8'h00, 1'b0, 32'(520 * MB));

    cur_req = "R4";
    for (int i = 8; i < 12; i++) wr(i, 0);
    for (int r = 0; r < 8; r++) wr(r, 16 * (r + 1));
    wr(2, 20);
    probe(20 * MB); probe(33 * MB); probe(40 * MB);
    wr(2, 32);
    probe(32 * MB); probe(31 * MB);

    cur_req = "R7";
    wr(2, 20);
    wr(3, 40);
    probe(25 * MB); probe(31 * MB); probe(32 * MB); probe(39 * MB); probe(40 * MB);

    cur_req = "R6";
    for (int r = 0; r < 8; r++) probe(longint'(r) * 5 * MB + 777);

    cur_req = "R9";
    wr(12, 8'hAA); wr(200, 8'h55); wr(255, 8'h01);
    for (int i = 10; i < 16; i++) step(8'(i), 8'h00, 1'b0, 32'(25 * MB));

    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra;
      int sel;
      sel = $urandom_range(0, 3);
      ra = (sel == 0) ? $urandom() : ($urandom() & 32'h3FFF_FFFF);
      if ($urandom_range(0, 3) == 0)
        step(8'($urandom_range(0, 15)), 8'($urandom()), 1'b1, ra);
      else
        step(8'($urandom_range(0, 15)), 8'h00, 1'b0, ra);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule